// File: doc/BRIEF.md
# HDLC Receive Frame Length Guard and Interrupt Coalescer

This block sits behind an HDLC receive deserializer, after flag removal. It sees one strobe per received byte, with marks for the first and last byte of each frame. It counts every byte of a frame, including address, control, payload and checksum bytes. It accepts bytes only up to a programmable limit. Once a frame goes over the limit, the block drops the rest of that frame and keeps tracking it until the last byte arrives. It then issues one status word that holds the frame length and a too-long flag.

The block also cuts the interrupt load when many short frames arrive. A down-counter of completed frames makes the frame-received interrupt pulse once per programmed number of frames, not once per frame. The counter reloads from the threshold input when it fires.

The byte stream has no back-pressure. The source cannot stall, so `byte_accept` is a per-byte keep/drop qualifier and not a ready signal. Every byte offered with `in_valid` is consumed in its cycle, whether it is accepted or not. `in_sof` and `in_eof` count only in cycles where `in_valid` is high. A one-byte frame has both marks set on the same byte.

Top module: `hdlc_rx_len_guard`

## Requirements
- R1: The counted length of a frame includes every byte from the byte marked `in_sof` through the byte marked `in_eof`, both included.
- R2: `max_len` is captured on the `in_sof` byte. Byte number k of the frame (the first byte is k=1) raises `byte_accept` in its own cycle exactly when k <= the captured limit. Changes to `max_len` in the middle of a frame are ignored.
- R3: Every byte after the limit is exceeded has `byte_accept` low, up to and including the `in_eof` byte.
- R4: `status_valid` pulses for one cycle, in the cycle after the `in_eof` byte. Overlong frames report at this same point and not earlier.
- R5: The reported length equals the byte count when the count is <= the limit, with `status_too_long`=0. Otherwise the length saturates at limit+1, with `status_too_long`=1. A limit of 0 makes every frame overlong.
- R6: Bytes offered with `in_valid` high while no frame is open, and without `in_sof`, are not accepted and produce no status.
- R7: An `in_sof` byte that arrives while a frame is open restarts counting. The abandoned frame produces no status.
- R8: `rx_irq` pulses together with the `status_valid` of the N-th completed frame, where N is the threshold. The counter then reloads from `frame_thresh` in that same cycle and counts a fresh group of N frames.
- R9: A threshold of 0 or 1 gives one `rx_irq` pulse with every frame status.
- R10: `frame_thresh` is sampled when the counter loads: on the first completed frame after reset, and at each interrupt. A change to it takes effect in the group that follows that load.
- R11: During and after reset, `status_valid`, `rx_irq` and `byte_accept` are low, and the frame counter starts a new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_sof | input | 1 | The byte is the first one after the opening flag |
| in_eof | input | 1 | The byte is the last one before the closing flag |
| max_len | input | LEN_W | Maximum frame length in bytes |
| frame_thresh | input | CNT_W | Number of frames per interrupt |
| byte_accept | output | 1 | Keep this byte (combinational on the inputs) |
| status_valid | output | 1 | Frame status is present this cycle |
| status_len | output | LEN_W+1 | Reported frame length |
| status_too_long | output | 1 | The frame exceeded the limit |
| rx_irq | output | 1 | Coalesced frame-received interrupt pulse |

## Verification
Two functions can land in the same cycle. The status of frame n and its possible interrupt come out in the same cycle that the `in_sof` byte of frame n+1 must be judged for acceptance against a newly captured limit. The bench provokes this by sending frames back to back, with no idle cycle between the `in_eof` byte and the next `in_sof`. A change to the threshold is also timed so that it lands on the very frame that fires and reloads the counter. A behavioural model built from byte counts and frame tallies predicts accept, status and interrupt on every clock, so any mix-up between the two frames or between the old and new threshold shows up as a mismatch.

// File: rtl/hdlc_rx_len_pkg.sv
package hdlc_rx_len_pkg;
  localparam int HRX_LEN_W = 16;
  localparam int HRX_CNT_W = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TAKE = 2'd1,
    PH_DROP = 2'd2
  } hrx_phase_e;
endpackage

// File: rtl/hrx_len_track.sv
module hrx_len_track
  import hdlc_rx_len_pkg::*;
#(
  parameter int LEN_W = HRX_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [LEN_W-1:0] max_len,
  output logic             byte_accept,
  output logic             done,
  output logic [LEN_W:0]   done_len,
  output logic             done_over
);
  hrx_phase_e       ph_q, b_ph, n_ph;
  logic [LEN_W-1:0] rem_q, b_rem, n_rem;
  logic [LEN_W:0]   len_q, b_len, n_len;
  logic             hit, room;

  always_comb begin
    hit   = in_valid && (in_sof || ph_q != PH_IDLE);
    b_ph  = in_sof ? PH_TAKE : ph_q;
    b_rem = in_sof ? max_len : rem_q;
    b_len = in_sof ? '0 : len_q;
    room  = (b_rem != '0);
    // the byte that first breaks the limit still bumps the length to limit+1
    n_len = (b_ph == PH_TAKE) ? b_len + 1'b1 : b_len;
    n_rem = room ? b_rem - 1'b1 : b_rem;
    n_ph  = (b_ph == PH_TAKE && !room) ? PH_DROP : b_ph;
    byte_accept = hit && (b_ph == PH_TAKE) && room;
    done      = hit && in_eof;
    done_len  = n_len;
    done_over = (n_ph == PH_DROP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      rem_q <= '0;
      len_q <= '0;
    end else if (hit) begin
      ph_q  <= in_eof ? PH_IDLE : n_ph;
      rem_q <= n_rem;
      len_q <= n_len;
    end
  end
endmodule

// File: rtl/hrx_irq_coalesce.sv
module hrx_irq_coalesce
  import hdlc_rx_len_pkg::*;
#(
  parameter int CNT_W = HRX_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [CNT_W-1:0] frame_thresh,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q, eff;
  logic             loaded_q;

  always_comb eff = loaded_q ? cnt_q : frame_thresh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      loaded_q <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (done) begin
        loaded_q <= 1'b1;
        if (eff <= CNT_W'(1)) begin
          irq   <= 1'b1;
          cnt_q <= frame_thresh;
        end else begin
          cnt_q <= eff - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_len_guard.sv
module hdlc_rx_len_guard
  import hdlc_rx_len_pkg::*;
#(
  parameter int LEN_W = HRX_LEN_W,
  parameter int CNT_W = HRX_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [LEN_W-1:0] max_len,
  input  logic [CNT_W-1:0] frame_thresh,
  output logic             byte_accept,
  output logic             status_valid,
  output logic [LEN_W:0]   status_len,
  output logic             status_too_long,
  output logic             rx_irq
);
  logic           done;
  logic [LEN_W:0] done_len;
  logic           done_over;

  hrx_len_track #(.LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .max_len(max_len), .byte_accept(byte_accept),
    .done(done), .done_len(done_len), .done_over(done_over)
  );

  hrx_irq_coalesce #(.CNT_W(CNT_W)) u_coal (
    .clk(clk), .rst_n(rst_n), .done(done),
    .frame_thresh(frame_thresh), .irq(rx_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_valid    <= 1'b0;
      status_len      <= '0;
      status_too_long <= 1'b0;
    end else begin
      status_valid <= done;
      if (done) begin
        status_len      <= done_len;
        status_too_long <= done_over;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_len_guard_chk.sv
module hdlc_rx_len_guard_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eof,
  input logic [LEN_W-1:0] max_len,
  input logic             byte_accept,
  input logic             status_valid,
  input logic [LEN_W:0]   status_len,
  input logic             status_too_long,
  input logic             rx_irq
);
  // R2: no byte is kept unless one is offered
  assert_accept_needs_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_accept |-> in_valid);

  // R4: status only follows a last byte
  assert_status_after_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> $past(in_valid && in_eof));

  // R8: interrupt rides on a frame status
  assert_irq_with_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> status_valid);

  // R5: one-byte frame under a nonzero limit reports length 1, not too long
  assert_single_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && in_eof && max_len != '0)
      |=> (status_valid && !status_too_long && status_len == (LEN_W+1)'(1)));

  // R5: too-long frames never report a zero length
  assert_overlong_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && status_too_long) |-> (status_len != '0));
endmodule

bind hdlc_rx_len_guard hdlc_rx_len_guard_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eof(in_eof), .max_len(max_len), .byte_accept(byte_accept),
  .status_valid(status_valid), .status_len(status_len),
  .status_too_long(status_too_long), .rx_irq(rx_irq)
);

// File: tb/sim_hdlc_rx_len_guard.sv
module sim_hdlc_rx_len_guard;
  localparam int PERIOD = 10;
  localparam int LW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [LW-1:0] max_len = '0;
  logic [CW-1:0] frame_thresh = '0;
  logic          byte_accept, status_valid, status_too_long, rx_irq;
  logic [LW:0]   status_len;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  string tag = "R11";

  // model state
  bit m_open = 0, m_have = 0;
  int m_seen = 0, m_cap = 0, m_since = 0, m_thr = 0;
  bit ex_sv = 0, ex_tl = 0, ex_irq = 0;
  int ex_len = 0;

  always #(PERIOD/2) clk = ~clk;

  hdlc_rx_len_guard #(.LEN_W(LW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .max_len(max_len), .frame_thresh(frame_thresh),
    .byte_accept(byte_accept), .status_valid(status_valid),
    .status_len(status_len), .status_too_long(status_too_long),
    .rx_irq(rx_irq)
  );

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_regs();
    chk("status_valid", int'(status_valid), int'(ex_sv));
    chk("rx_irq", int'(rx_irq), int'(ex_irq));
    if (ex_sv) begin
      chk("status_len", int'(status_len), ex_len);
      chk("status_too_long", int'(status_too_long), int'(ex_tl));
    end
  endtask

  // one clock: check registered outputs, drive, check accept, predict
  task automatic step(bit v, bit s, bit e);
    bit acc;
    int eff;
    check_regs();
    in_valid = v; in_sof = s; in_eof = e;
    #1;
    acc = 0; ex_sv = 0; ex_irq = 0;
    if (v && (s || m_open)) begin
      if (s) begin m_open = 1; m_seen = 0; m_cap = int'(max_len); end
      m_seen++;
      acc = (m_seen <= m_cap);
      if (e) begin
        m_open = 0;
        ex_sv  = 1;
        ex_tl  = (m_seen > m_cap);
        ex_len = ex_tl ? m_cap + 1 : m_seen;
        if (!m_have) begin m_have = 1; m_thr = int'(frame_thresh); end
        m_since++;
        eff = (m_thr < 1) ? 1 : m_thr;
        if (m_since >= eff) begin
          ex_irq = 1; m_since = 0; m_thr = int'(frame_thresh);
        end
      end
    end
    chk("byte_accept", int'(byte_accept), int'(acc));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic frame(int n);
    for (int i = 1; i <= n; i++) step(1'b1, i == 1, i == n);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    frame_thresh = 16'd1;
    max_len = 16'd8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R11";
    // reset state: outputs low while still in reset
    chk("status_valid in reset", int'(status_valid), 0);
    chk("rx_irq in reset", int'(rx_irq), 0);
    chk("byte_accept in reset", int'(byte_accept), 0);
    rst_n = 1'b1;
    idle(2);

    tag = "R1"; frame(5); idle(1);
    tag = "R2"; frame(8); idle(1);              // exactly the limit
    tag = "R3"; frame(12); idle(1);             // overlong, bytes 9..12 dropped
    tag = "R4"; frame(9); frame(3); idle(1);    // overlong then back-to-back
    tag = "R5"; max_len = 16'd0; frame(3); frame(1); idle(1);
    max_len = 16'd8;
    tag = "R6"; step(1, 0, 0); step(1, 0, 1); step(1, 0, 0); idle(1);
    tag = "R7"; step(1, 1, 0); step(1, 0, 0); step(1, 0, 0); frame(2); idle(1);
    tag = "R2";                                  // mid-frame limit change ignored
    max_len = 16'd4;
    step(1, 1, 0);
    max_len = 16'd20;
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); step(1, 0, 1);
    idle(1);
    max_len = 16'd8;

    tag = "R8"; frame_thresh = 16'd3;
    frame(2); frame(1); frame(4); frame(1); frame(1); frame(3); frame(2);
    idle(2);
    frame(1); frame(1);
    tag = "R10";                                 // change lands on the firing frame
    frame_thresh = 16'd2;
    frame(1); frame(2); frame(1); frame(1); frame(1);
    idle(1);
    tag = "R9"; frame_thresh = 16'd0;
    frame(1); frame(1); frame(1); frame(2);
    frame_thresh = 16'd1;
    frame(1); frame(1); frame(3); frame(1);
    tag = "R4"; frame(10); frame(1); idle(3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule